// File: doc/BRIEF.md
# General-Purpose Event Status and Enable Block with SCI

This block holds a small bank of general-purpose event flags on a byte-wide I/O bus and drives the system control interrupt (SCI) level that reports them. Event inputs from the platform each set a sticky status bit. Software reads the status bytes to find the source and clears bits by writing ones to them. A parallel set of enable bytes selects which events may raise the interrupt.

The address window is split in two halves. The low half holds the status bytes and the high half holds the enable bytes. Each byte is selected by its offset from the base of its half. The interrupt is raised when an event pulse arrives on a bit whose enable is set. It is lowered only by two software actions on one bit, the hot-plug event bit: clearing that bit's status, or turning off that bit's enable. Reads are combinational. Any address beyond the window reads as zero and ignores writes.

Top module: `gpe_sci_block`

## Requirements
- R1: After reset every status byte and enable byte reads 0x00 and `sci_out` is low.
- R2: With the default of two status bytes, offsets 0 and 1 are status bytes 0 and 1, and offsets 2 and 3 are enable bytes 0 and 1. A read with `bus_rd` high returns the current byte at that offset in the same cycle.
- R3: A one-cycle pulse on `evt_pulse[i]` sets status bit i, which is bit i%8 of status byte i/8, from the next cycle on. The bit stays set until software clears it.
- R4: A write to a status byte clears exactly the bits where the written value has a one. Bits written as zero keep their value.
- R5: Enable bytes are plain read/write storage. A write stores the value and a read returns it.
- R6: An event pulse on a bit whose enable is set, counting an enable written in the same cycle, raises `sci_out` from the next cycle on. An event on a disabled bit does not raise it. Setting the enable of a bit whose status is already set does not raise it either.
- R7: The hot-plug event is bit 3 of status byte 0 and enable byte 0. When the interrupt is asserted and status bit 3 is set, a status write to byte 0 with bit 3 at one lowers `sci_out` from the next cycle on. Status writes that leave bit 3 alone keep `sci_out` high.
- R8: When the interrupt is asserted, a write to enable byte 0 with bit 3 at zero lowers `sci_out` and clears the asserted state. Writes to enable byte 0 with bit 3 at one, and writes to enable byte 1, leave `sci_out` unchanged.
- R9: Reads at offsets of 4 and above return 0x00. Writes there change no status byte, no enable byte and not `sci_out`.
- R10: When an event pulse and a clearing status write hit the same bit in the same cycle, the bit ends up set. If that bit is enabled, `sci_out` ends up high.
- R11: A status write with bit 3 at one does not lower `sci_out` when status bit 3 was already clear before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (3) | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per byte write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 8 | Combinational read data |
| evt_pulse | input | 8*STS_BYTES (16) | One-cycle event pulses, one per status bit |
| sci_out | output | 1 | SCI interrupt level |

## Verification
A status bit that is stuck or wrongly cleared shows on the next read of its byte. A wrong enable or asserted-state bit does not show at once. It appears only when a later event fails to raise `sci_out`, or when a later software write on bit 3 fails to lower it. For that reason the stimulus sets up each asserted state and then exercises every lowering path and every path that must not lower. The interrupt level is checked one cycle after each such write, so a fault becomes visible within a single cycle of the action that exposes it.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_STS  = 2'd1,
        RGN_EN   = 2'd2
    } gpe_region_e;

    typedef struct packed {
        logic flag;
        logic line;
    } gpe_sci_t;

endpackage

// File: rtl/gpe_addr_dec.sv
module gpe_addr_dec
    import gpe_pkg::*;
#(
    parameter int STS_BYTES = 2,
    parameter int ADDR_W    = 3,
    localparam int IDX_W    = (STS_BYTES > 1) ? $clog2(STS_BYTES) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    output gpe_region_e          region,
    output logic [IDX_W-1:0]     idx,
    output logic [STS_BYTES-1:0] sts_sel,
    output logic [STS_BYTES-1:0] en_sel
);

    always_comb begin
        int off;
        off     = int'(addr);
        region  = RGN_NONE;
        idx     = '0;
        sts_sel = '0;
        en_sel  = '0;
        if (off < STS_BYTES) begin
            region       = RGN_STS;
            idx          = IDX_W'(off);
            sts_sel[off] = 1'b1;
        end else if (off < 2 * STS_BYTES) begin
            region                   = RGN_EN;
            idx                      = IDX_W'(off - STS_BYTES);
            en_sel[off - STS_BYTES]  = 1'b1;
        end
    end

endmodule

// File: rtl/gpe_sts_bank.sv
module gpe_sts_bank
    import gpe_pkg::*;
#(
    parameter int STS_BYTES = 2,
    localparam int NUM_BITS = STS_BYTES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [STS_BYTES-1:0] sel,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [NUM_BITS-1:0]  evt,
    output logic [NUM_BITS-1:0]  sts_q
);

    typedef struct packed {
        logic [NUM_BITS-1:0] bits;
    } sts_t;

    sts_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < STS_BYTES; b++) begin
            if (wr_en && sel[b]) begin
                st_d.bits[b*BYTE_W +: BYTE_W] = st_q.bits[b*BYTE_W +: BYTE_W] & ~wr_data;
            end
        end
        st_d.bits = st_d.bits | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_q = st_q.bits;

    // R3
    evt_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((sts_q & $past(evt)) == $past(evt)));

    // R3
    rise_only_by_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(evt)) == '0));

endmodule

// File: rtl/gpe_en_bank.sv
module gpe_en_bank
    import gpe_pkg::*;
#(
    parameter int STS_BYTES = 2,
    localparam int NUM_BITS = STS_BYTES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [STS_BYTES-1:0] sel,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [NUM_BITS-1:0]  en_d_o,
    output logic [NUM_BITS-1:0]  en_q
);

    typedef struct packed {
        logic [NUM_BITS-1:0] bits;
    } en_t;

    en_t en_d, en_qs;

    always_comb begin
        en_d = en_qs;
        for (int b = 0; b < STS_BYTES; b++) begin
            if (wr_en && sel[b]) en_d.bits[b*BYTE_W +: BYTE_W] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_qs <= '0;
        else        en_qs <= en_d;
    end

    assign en_d_o = en_d.bits;
    assign en_q   = en_qs.bits;

    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));

endmodule

// File: rtl/gpe_sci_ctrl.sv
module gpe_sci_ctrl
    import gpe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic hp_sts_drop,
    input  logic hp_en_off,
    output logic sci_line
);

    gpe_sci_t sci_d, sci_q;

    always_comb begin
        sci_d = sci_q;
        if (sci_q.flag && hp_sts_drop) begin
            sci_d.line = 1'b0;
        end
        if (sci_q.flag && hp_en_off) begin
            sci_d.flag = 1'b0;
            sci_d.line = 1'b0;
        end
        if (raise) begin
            sci_d.flag = 1'b1;
            sci_d.line = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sci_q <= '0;
        else        sci_q <= sci_d;
    end

    assign sci_line = sci_q.line;

    // R6
    line_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_q.line |-> sci_q.flag);

    // R6
    rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci_line) |-> $past(raise));

    // R7
    sts_drop_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_sts_drop && sci_q.flag && !raise) |=> !sci_line);

    // R8
    en_off_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_en_off && sci_q.flag && !raise) |=> (!sci_line && !sci_q.flag));

endmodule

// File: rtl/gpe_sci_block.sv
module gpe_sci_block
    import gpe_pkg::*;
#(
    parameter int STS_BYTES = 2,
    parameter int ADDR_W    = 3,
    parameter int HP_BIT    = 3,
    localparam int NUM_BITS = STS_BYTES * BYTE_W,
    localparam int IDX_W    = (STS_BYTES > 1) ? $clog2(STS_BYTES) : 1,
    localparam int HP_BYTE  = HP_BIT / BYTE_W,
    localparam int HP_POS   = HP_BIT % BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [NUM_BITS-1:0] evt_pulse,
    output logic                sci_out
);

    gpe_region_e          region;
    logic [IDX_W-1:0]     idx;
    logic [STS_BYTES-1:0] sts_sel, en_sel;
    logic [NUM_BITS-1:0]  sts_q, en_q, en_d;
    logic                 raise, hp_sts_drop, hp_en_off;

    gpe_addr_dec #(.STS_BYTES(STS_BYTES), .ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .region  (region),
        .idx     (idx),
        .sts_sel (sts_sel),
        .en_sel  (en_sel)
    );

    gpe_sts_bank #(.STS_BYTES(STS_BYTES)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .sel     (sts_sel),
        .wr_data (bus_wdata),
        .evt     (evt_pulse),
        .sts_q   (sts_q)
    );

    gpe_en_bank #(.STS_BYTES(STS_BYTES)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .sel     (en_sel),
        .wr_data (bus_wdata),
        .en_d_o  (en_d),
        .en_q    (en_q)
    );

    always_comb begin
        raise       = |(evt_pulse & en_d);
        hp_sts_drop = bus_wr && sts_sel[HP_BYTE] && sts_q[HP_BIT] && bus_wdata[HP_POS];
        hp_en_off   = bus_wr && en_sel[HP_BYTE] && !bus_wdata[HP_POS];
    end

    gpe_sci_ctrl u_sci (
        .clk         (clk),
        .rst_n       (rst_n),
        .raise       (raise),
        .hp_sts_drop (hp_sts_drop),
        .hp_en_off   (hp_en_off),
        .sci_line    (sci_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (region)
                RGN_STS: bus_rdata = sts_q[idx*BYTE_W +: BYTE_W];
                RGN_EN:  bus_rdata = en_q[idx*BYTE_W +: BYTE_W];
                default: bus_rdata = '0;
            endcase
        end
    end

    // R9
    out_of_window_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (int'(bus_addr) >= 2 * STS_BYTES)) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_gpe_sci_block.sv
module sim_gpe_sci_block;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] evt_pulse = '0;
    logic        sci_out;
    logic        probe_sci = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit    kind_q[$];
    byte   exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    gpe_sci_block u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .evt_pulse (evt_pulse),
        .sci_out   (sci_out)
    );

    // monitor: pops one expected item for every read or probe cycle
    always @(posedge clk) begin
        #2;
        if (bus_rd || probe_sci) begin
            if (kind_q.size() == 0) begin
                errors++;
                $display("FAIL monitor: result with empty queue actual=%0h expected=none", bus_rdata);
            end else begin
                bit    k;
                byte   e;
                string t;
                logic [7:0] got;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                got = k ? {7'b0, sci_out} : bus_rdata;
                checks++;
                if (got !== e) begin
                    errors++;
                    $display("FAIL %s actual=%02h expected=%02h", t, got, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [15:0] ev);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_pulse = ev;
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse = '0;
    endtask

    task automatic pulse(input logic [15:0] ev);
        @(negedge clk);
        evt_pulse = ev;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        kind_q.push_back(1'b0); exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic sci_is(input logic e, input string t);
        @(negedge clk);
        probe_sci = 1'b1;
        kind_q.push_back(1'b1); exp_q.push_back({7'b0, e}); tag_q.push_back(t);
        @(negedge clk);
        probe_sci = 1'b0;
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, 8'h00, "R1 sts0 after reset");
        rd(1, 8'h00, "R1 sts1 after reset");
        rd(2, 8'h00, "R1 en0 after reset");
        rd(3, 8'h00, "R1 en1 after reset");
        sci_is(1'b0, "R1 sci after reset");

        // R5 / R2 enable storage and map
        wr(2, 8'hA5, '0);
        wr(3, 8'h3C, '0);
        rd(2, 8'hA5, "R5 en0 readback");
        rd(3, 8'h3C, "R2 en1 at offset 3");
        wr(2, 8'h00, '0);
        wr(3, 8'h00, '0);

        // R3 events set status; R6 disabled event does not raise
        pulse(16'h0102);
        rd(0, 8'h02, "R3 sts0 bit1 set");
        rd(1, 8'h01, "R3 sts1 bit0 set (evt 8)");
        sci_is(1'b0, "R6 disabled event keeps sci low");
        wr(2, 8'h02, '0);
        sci_is(1'b0, "R6 late enable does not raise");

        // R4 write-1-to-clear
        wr(0, 8'h00, '0);
        rd(0, 8'h02, "R4 zero write keeps bits");
        wr(1, 8'h01, '0);
        rd(1, 8'h00, "R4 sts1 cleared");
        wr(0, 8'h02, '0);
        rd(0, 8'h00, "R4 sts0 cleared");

        // R6 enabled event raises
        pulse(16'h0002);
        sci_is(1'b1, "R6 enabled event raises sci");
        rd(0, 8'h02, "R3 sts0 bit1 after event");

        // R11 hot-plug status already clear: no lowering
        wr(0, 8'h08, '0);
        sci_is(1'b1, "R11 clear of idle bit3 keeps sci");
        // R7 clearing another bit keeps sci
        wr(0, 8'h02, '0);
        sci_is(1'b1, "R7 clear of bit1 keeps sci");
        rd(0, 8'h00, "R4 sts0 bit1 cleared");

        // R8 non-lowering enable writes
        wr(3, 8'h00, '0);
        sci_is(1'b1, "R8 en1 write keeps sci");
        wr(2, 8'h0A, '0);
        sci_is(1'b1, "R8 en0 with bit3 set keeps sci");
        wr(2, 8'h02, '0);
        sci_is(1'b0, "R8 en0 bit3 clear lowers sci");
        rd(2, 8'h02, "R5 en0 holds 02");

        // R7 hot-plug status clear lowers
        wr(2, 8'h08, '0);
        pulse(16'h0008);
        sci_is(1'b1, "R6 hot-plug event raises sci");
        rd(0, 8'h08, "R3 sts0 bit3 set");
        wr(0, 8'h08, '0);
        sci_is(1'b0, "R7 hot-plug status clear lowers sci");
        rd(0, 8'h00, "R7 sts0 bit3 cleared");

        // R10 event and clear in the same cycle
        pulse(16'h0008);
        sci_is(1'b1, "R6 re-raise on hot-plug");
        wr(2, 8'h00, '0);
        sci_is(1'b0, "R8 disable lowers sci");
        wr(0, 8'h08, 16'h0008);
        rd(0, 8'h08, "R10 event wins over clear");
        sci_is(1'b0, "R10 disabled event keeps sci low");
        wr(2, 8'h08, '0);
        wr(0, 8'h08, 16'h0008);
        sci_is(1'b1, "R10 enabled event with clear raises sci");
        rd(0, 8'h08, "R10 bit3 still set");

        // R9 out-of-window accesses
        wr(4, 8'hFF, '0);
        wr(7, 8'hFF, '0);
        rd(4, 8'h00, "R9 read offset 4");
        rd(7, 8'h00, "R9 read offset 7");
        rd(0, 8'h08, "R9 sts0 untouched");
        rd(1, 8'h00, "R9 sts1 untouched");
        rd(2, 8'h08, "R9 en0 untouched");
        rd(3, 8'h00, "R9 en1 untouched");
        sci_is(1'b1, "R9 sci untouched");

        repeat (3) @(negedge clk);
        if (kind_q.size() != 0) begin
            errors++;
            $display("FAIL monitor: %0d unchecked items actual=pending expected=0", kind_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule